// File: doc/BRIEF.md
# RISC Instruction Decoder

This block turns one 32-bit instruction word into the fields and control signals that a simple load/store datapath needs to execute it. It is purely combinational: the word comes in, and in the same cycle the decoder reports the two source register indices, the destination register index already selected, an immediate extended the way the opcode requires, and the 26-bit jump target. Alongside these come the control lines that steer the register file, the ALU, data memory and the next-PC logic.

Three encodings are recognised. The first is a register format: op, rs, rt, rd, shift amount and function, with widths 6/5/5/5/5/6 from the top bit down. The second is an immediate format: op, rs, rt and a 16-bit immediate. The third is a jump format: op and a 26-bit target. In register format the function field selects the operation. Every other instruction is chosen by its opcode alone. Any opcode, or any function value under opcode 0, outside the supported subset raises an illegal-instruction flag. When that flag is up, no state-changing control is active.

Top module: `insn_decode`

## Requirements
- R1: rs_idx is instr[25:21], rt_idx is instr[20:16] and jmp_tgt is instr[25:0] for every instruction word.
- R2: With opcode 0, function codes 32 (add), 34 (sub), 36 (and), 37 (or) and 42 (slt) set reg_we=1, dst_sel=1 (rd) and wr_idx=instr[15:11]. They also set alu_src_imm=0 and alu_op to 0, 1, 2, 3 and 4 respectively.
- R3: Opcode 0 with function 8 (register jump) sets jump_reg=1, with reg_we=0, jump=0 and no memory access.
- R4: Opcodes 8 (add imm, alu_op 0) and 10 (set-less-than imm, alu_op 4) sign-extend bit 15 of the immediate. Opcodes 12 (and imm, alu_op 2) and 13 (or imm, alu_op 3) zero-extend it. All four write rt (dst_sel=0) with alu_src_imm=1.
- R5: Opcode 15 (load upper) gives imm_ext = {imm, 16'h0000} and alu_op 5 (pass operand B), and writes rt.
- R6: Opcodes 35 (word load) and 32 (byte load) set mem_rd=1, reg_we=1, dst_sel=0, alu_op 0, alu_src_imm=1 and a sign-extended offset. mem_byte is 1 only for opcode 32.
- R7: Opcodes 43 (word store) and 40 (byte store) set mem_wr=1, reg_we=0 and a sign-extended offset. mem_byte is 1 only for opcode 40.
- R8: Opcode 4 gives br_type=1 (equal) and opcode 5 gives br_type=2 (not equal). Both use alu_op 1, a sign-extended offset and reg_we=0.
- R9: Opcode 2 sets jump=1 with reg_we=0. Opcode 3 sets jump=1, link=1, reg_we=1, dst_sel=2 and wr_idx=31.
- R10: Any other opcode, or opcode 0 with any other function, sets illegal=1. It also forces reg_we, mem_rd, mem_wr, jump, jump_reg and link to 0, and br_type to 0.
- R11: At most one of mem_rd, mem_wr, a nonzero br_type, jump and jump_reg is active for any instruction word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source register index |
| wr_idx | output | 5 | Selected destination register index |
| dst_sel | output | 2 | Destination choice: 0 rt, 1 rd, 2 link register |
| imm_ext | output | 32 | Immediate after sign, zero or upper placement |
| jmp_tgt | output | 26 | Jump target field |
| reg_we | output | 1 | Register file write enable |
| alu_op | output | 3 | 0 add, 1 sub, 2 and, 3 or, 4 set-less-than, 5 pass B |
| alu_src_imm | output | 1 | ALU operand B comes from imm_ext |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| mem_byte | output | 1 | Access is one byte instead of one word |
| br_type | output | 2 | 0 none, 1 branch if equal, 2 branch if not equal |
| jump | output | 1 | Absolute jump to target field |
| jump_reg | output | 1 | Jump to address held in rs |
| link | output | 1 | Write return address to register 31 |
| illegal | output | 1 | Encoding outside the supported subset |

## Verification
The bench feeds immediates with bit 15 set to the sign-extending and zero-extending opcodes alike. A decoder that swapped the extension rule would show all-ones or all-zeros in the upper half. It also checks register jump and unknown function codes under opcode 0, where a decoder that treated every opcode-0 word as an ALU write would corrupt rd. The word of all zeros and every unlisted opcode must raise the illegal flag with all writes off; a default branch that left reg_we or mem_wr set would show up there. A sweep over all 64 opcodes confirms that memory, branch and jump controls never appear together and that the link destination is 31.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 6;
  localparam int REG_W  = 5;
  localparam int FN_W   = 6;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = WORD_W - OP_W;

  localparam logic [OP_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'd2;
  localparam logic [OP_W-1:0] OPC_JAL   = 6'd3;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'd5;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OP_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OP_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OP_W-1:0] OPC_LUI   = 6'd15;
  localparam logic [OP_W-1:0] OPC_LDB   = 6'd32;
  localparam logic [OP_W-1:0] OPC_LDW   = 6'd35;
  localparam logic [OP_W-1:0] OPC_STB   = 6'd40;
  localparam logic [OP_W-1:0] OPC_STW   = 6'd43;

  localparam logic [FN_W-1:0] FN_JR  = 6'd8;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2,
    ALU_OR = 3'd3, ALU_SLT = 3'd4, ALU_PASSB = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_e;
  typedef enum logic [1:0] {BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2} br_e;
  typedef enum logic [1:0] {EXT_SIGN = 2'd0, EXT_ZERO = 2'd1, EXT_UPPER = 2'd2} ext_e;

  typedef struct packed {
    logic    reg_we;
    dst_e    dst;
    alu_op_e alu;
    logic    src_imm;
    logic    mem_rd;
    logic    mem_wr;
    logic    mem_byte;
    br_e     br;
    logic    jump;
    logic    jump_reg;
    logic    link;
    logic    illegal;
    ext_e    ext;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] ext_sign(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] ext_zero(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){1'b0}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] ext_upper(input logic [IMM_W-1:0] v);
    return {v, {(WORD_W-IMM_W){1'b0}}};
  endfunction
endpackage

// File: rtl/dec_fields.sv
module dec_fields
  import dec_pkg::*;
#(
  parameter int P_WORD_W = WORD_W,
  parameter int P_OP_W   = OP_W,
  parameter int P_REG_W  = REG_W,
  parameter int P_FN_W   = FN_W,
  parameter int P_IMM_W  = IMM_W
) (
  input  logic [P_WORD_W-1:0]        instr,
  output logic [P_OP_W-1:0]          op,
  output logic [P_REG_W-1:0]         rs,
  output logic [P_REG_W-1:0]         rt,
  output logic [P_REG_W-1:0]         rd,
  output logic [P_FN_W-1:0]          funct,
  output logic [P_IMM_W-1:0]         imm,
  output logic [P_WORD_W-P_OP_W-1:0] tgt
);
  localparam int OP_LSB = P_WORD_W - P_OP_W;
  localparam int RS_LSB = OP_LSB - P_REG_W;
  localparam int RT_LSB = RS_LSB - P_REG_W;
  localparam int RD_LSB = RT_LSB - P_REG_W;

  assign op    = instr[P_WORD_W-1:OP_LSB];
  assign rs    = instr[OP_LSB-1:RS_LSB];
  assign rt    = instr[RS_LSB-1:RT_LSB];
  assign rd    = instr[RT_LSB-1:RD_LSB];
  assign funct = instr[P_FN_W-1:0];
  assign imm   = instr[P_IMM_W-1:0];
  assign tgt   = instr[OP_LSB-1:0];
endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [FN_W-1:0] funct,
  output ctrl_t           ctl
);
  always_comb begin
    ctl = '0;
    case (op)
      OPC_REG: begin
        ctl.reg_we = 1'b1;
        ctl.dst    = DST_RD;
        case (funct)
          FN_ADD:  ctl.alu = ALU_ADD;
          FN_SUB:  ctl.alu = ALU_SUB;
          FN_AND:  ctl.alu = ALU_AND;
          FN_OR:   ctl.alu = ALU_OR;
          FN_SLT:  ctl.alu = ALU_SLT;
          FN_JR: begin
            ctl.reg_we   = 1'b0;
            ctl.dst      = DST_RT;
            ctl.jump_reg = 1'b1;
          end
          default: begin
            ctl.reg_we  = 1'b0;
            ctl.dst     = DST_RT;
            ctl.illegal = 1'b1;
          end
        endcase
      end
      OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI: begin
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
        case (op)
          OPC_ADDI: ctl.alu = ALU_ADD;
          OPC_SLTI: ctl.alu = ALU_SLT;
          OPC_ANDI: begin ctl.alu = ALU_AND; ctl.ext = EXT_ZERO; end
          default:  begin ctl.alu = ALU_OR;  ctl.ext = EXT_ZERO; end
        endcase
      end
      OPC_LUI: begin
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.alu     = ALU_PASSB;
        ctl.ext     = EXT_UPPER;
      end
      OPC_LDW, OPC_LDB: begin
        ctl.reg_we   = 1'b1;
        ctl.src_imm  = 1'b1;
        ctl.mem_rd   = 1'b1;
        ctl.mem_byte = (op == OPC_LDB);
      end
      OPC_STW, OPC_STB: begin
        ctl.src_imm  = 1'b1;
        ctl.mem_wr   = 1'b1;
        ctl.mem_byte = (op == OPC_STB);
      end
      OPC_BEQ: begin ctl.alu = ALU_SUB; ctl.br = BR_EQ; end
      OPC_BNE: begin ctl.alu = ALU_SUB; ctl.br = BR_NE; end
      OPC_JMP: ctl.jump = 1'b1;
      OPC_JAL: begin
        ctl.jump   = 1'b1;
        ctl.link   = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.dst    = DST_LINK;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/dec_imm.sv
module dec_imm
  import dec_pkg::*;
(
  input  logic [IMM_W-1:0]  imm,
  input  ext_e              ext,
  output logic [WORD_W-1:0] imm_ext
);
  always_comb begin
    case (ext)
      EXT_ZERO:  imm_ext = ext_zero(imm);
      EXT_UPPER: imm_ext = ext_upper(imm);
      default:   imm_ext = ext_sign(imm);
    endcase
  end
endmodule

// File: rtl/insn_decode.sv
module insn_decode
  import dec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [4:0]  rs_idx,
  output logic [4:0]  rt_idx,
  output logic [4:0]  wr_idx,
  output logic [1:0]  dst_sel,
  output logic [31:0] imm_ext,
  output logic [25:0] jmp_tgt,
  output logic        reg_we,
  output logic [2:0]  alu_op,
  output logic        alu_src_imm,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        mem_byte,
  output logic [1:0]  br_type,
  output logic        jump,
  output logic        jump_reg,
  output logic        link,
  output logic        illegal
);
  localparam logic [REG_W-1:0] LINK_REG = {REG_W{1'b1}};

  logic [OP_W-1:0]  f_op;
  logic [REG_W-1:0] f_rs, f_rt, f_rd;
  logic [FN_W-1:0]  f_funct;
  logic [IMM_W-1:0] f_imm;
  ctrl_t            ctl;

  dec_fields u_fields (
    .instr (instr_i),
    .op    (f_op),
    .rs    (f_rs),
    .rt    (f_rt),
    .rd    (f_rd),
    .funct (f_funct),
    .imm   (f_imm),
    .tgt   (jmp_tgt)
  );

  dec_ctrl u_ctrl (
    .op    (f_op),
    .funct (f_funct),
    .ctl   (ctl)
  );

  dec_imm u_imm (
    .imm     (f_imm),
    .ext     (ctl.ext),
    .imm_ext (imm_ext)
  );

  always_comb begin
    case (ctl.dst)
      DST_RD:   wr_idx = f_rd;
      DST_LINK: wr_idx = LINK_REG;
      default:  wr_idx = f_rt;
    endcase
  end

  assign rs_idx      = f_rs;
  assign rt_idx      = f_rt;
  assign dst_sel     = ctl.dst;
  assign reg_we      = ctl.reg_we;
  assign alu_op      = ctl.alu;
  assign alu_src_imm = ctl.src_imm;
  assign mem_rd      = ctl.mem_rd;
  assign mem_wr      = ctl.mem_wr;
  assign mem_byte    = ctl.mem_byte;
  assign br_type     = ctl.br;
  assign jump        = ctl.jump;
  assign jump_reg    = ctl.jump_reg;
  assign link        = ctl.link;
  assign illegal     = ctl.illegal;

  // named events for the checks below
  logic flow_event, zext_sel, any_write;
  assign flow_event = (ctl.br != BR_NONE);
  assign zext_sel   = (ctl.ext == EXT_ZERO);
  assign any_write  = ctl.reg_we | ctl.mem_wr | ctl.mem_rd;

  always_comb begin
    if (!$isunknown(instr_i)) begin
      AST_ILLEGAL_QUIET: assert (!illegal || (!any_write && !jump && !jump_reg && !link && !flow_event)); // R10
      AST_ONE_EFFECT: assert ($countones({mem_rd, mem_wr, flow_event, jump, jump_reg}) <= 1); // R11
      AST_LINK_DEST: assert (!link || (reg_we && wr_idx == LINK_REG && jump)); // R9
      AST_ZEXT_UPPER: assert (!zext_sel || imm_ext[WORD_W-1:IMM_W] == '0); // R4
      AST_STORE_NO_WE: assert (!mem_wr || !reg_we); // R7
      AST_RS_FIELD: assert (rs_idx == instr_i[25:21] && rt_idx == instr_i[20:16]); // R1
    end
  end
endmodule

// File: tb/test_insn_decode.sv
module test_insn_decode;
  logic        clk = 1'b0;
  logic [31:0] instr;
  logic [4:0]  rs_idx, rt_idx, wr_idx;
  logic [1:0]  dst_sel, br_type;
  logic [31:0] imm_ext;
  logic [25:0] jmp_tgt;
  logic [2:0]  alu_op;
  logic reg_we, alu_src_imm, mem_rd, mem_wr, mem_byte, jump, jump_reg, link, illegal;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  insn_decode i_insn_decode (
    .instr_i(instr), .rs_idx(rs_idx), .rt_idx(rt_idx), .wr_idx(wr_idx),
    .dst_sel(dst_sel), .imm_ext(imm_ext), .jmp_tgt(jmp_tgt), .reg_we(reg_we),
    .alu_op(alu_op), .alu_src_imm(alu_src_imm), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_byte(mem_byte), .br_type(br_type), .jump(jump), .jump_reg(jump_reg),
    .link(link), .illegal(illegal)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input logic [15:0] im);
    return {6'(op), 5'(rs), 5'(rt), im};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    @(posedge clk);
    #1;
  endtask

  // full control vector check: we, dst, wr, alu, src, rd, wr, byte, br, j, jr, link, ill
  task automatic chk_ctl(input string req, input logic we, input int dst, input int wr,
                         input int alu, input logic src, input logic mr, input logic mw,
                         input logic mb, input int br, input logic j, input logic jr,
                         input logic lk, input logic il);
    chk(req, "reg_we", 32'(reg_we), 32'(we));
    if (we) begin
      chk(req, "dst_sel", 32'(dst_sel), 32'(dst));
      chk(req, "wr_idx", 32'(wr_idx), 32'(wr));
    end
    if (!il) begin
      chk(req, "alu_op", 32'(alu_op), 32'(alu));
      chk(req, "alu_src_imm", 32'(alu_src_imm), 32'(src));
    end
    chk(req, "mem_rd", 32'(mem_rd), 32'(mr));
    chk(req, "mem_wr", 32'(mem_wr), 32'(mw));
    if (mr || mw) chk(req, "mem_byte", 32'(mem_byte), 32'(mb));
    chk(req, "br_type", 32'(br_type), 32'(br));
    chk(req, "jump", 32'(jump), 32'(j));
    chk(req, "jump_reg", 32'(jump_reg), 32'(jr));
    chk(req, "link", 32'(link), 32'(lk));
    chk(req, "illegal", 32'(illegal), 32'(il));
  endtask

  task automatic t_zero_word;
    apply(32'h0000_0000);
    chk_ctl("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_fields;
    apply(32'hABCD_1234);
    chk("R1", "rs_idx", 32'(rs_idx), 32'(5'b11110));
    chk("R1", "rt_idx", 32'(rt_idx), 32'(5'b01101));
    chk("R1", "jmp_tgt", 32'(jmp_tgt), 32'h03CD_1234);
  endtask

  task automatic t_reg_ops;
    int fns[5] = '{32, 34, 36, 37, 42};
    for (int k = 0; k < 5; k++) begin
      apply(enc_r(17, 18, 9 + k, fns[k]));
      chk_ctl("R2", 1, 1, 9 + k, k, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    apply(32'b000000_10001_10010_01000_00000_100000);
    chk("R2", "wr_idx add", 32'(wr_idx), 32'd8);
  endtask

  task automatic t_reg_jump;
    apply(enc_r(31, 0, 7, 8));
    chk_ctl("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R3", "rs_idx", 32'(rs_idx), 32'd31);
  endtask

  task automatic t_imm_arith;
    apply(enc_i(8, 3, 4, 16'hFFF0));
    chk_ctl("R4", 1, 0, 4, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", "addi ext", imm_ext, 32'hFFFF_FFF0);
    apply(enc_i(10, 3, 5, 16'h8001));
    chk_ctl("R4", 1, 0, 5, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", "slti ext", imm_ext, 32'hFFFF_8001);
    apply(enc_i(12, 3, 6, 16'hFFF0));
    chk_ctl("R4", 1, 0, 6, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", "andi ext", imm_ext, 32'h0000_FFF0);
    apply(enc_i(13, 3, 7, 16'h8000));
    chk_ctl("R4", 1, 0, 7, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", "ori ext", imm_ext, 32'h0000_8000);
    apply(enc_i(8, 3, 4, 16'h7FFF));
    chk("R4", "addi positive", imm_ext, 32'h0000_7FFF);
  endtask

  task automatic t_upper;
    apply(enc_i(15, 0, 12, 16'hAAAA));
    chk_ctl("R5", 1, 0, 12, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5", "lui ext", imm_ext, 32'hAAAA_0000);
  endtask

  task automatic t_loads;
    apply(enc_i(35, 18, 9, 16'h0020));
    chk_ctl("R6", 1, 0, 9, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R6", "lw ext", imm_ext, 32'h0000_0020);
    apply(enc_i(32, 18, 10, 16'h8000));
    chk_ctl("R6", 1, 0, 10, 0, 1, 1, 0, 1, 0, 0, 0, 0, 0);
    chk("R6", "lb ext", imm_ext, 32'hFFFF_8000);
  endtask

  task automatic t_stores;
    apply(enc_i(43, 19, 9, 16'hFFFC));
    chk_ctl("R7", 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R7", "sw ext", imm_ext, 32'hFFFF_FFFC);
    apply(enc_i(40, 19, 9, 16'h0004));
    chk_ctl("R7", 0, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_branches;
    apply(enc_i(4, 8, 9, 16'hFFFE));
    chk_ctl("R8", 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R8", "beq ext", imm_ext, 32'hFFFF_FFFE);
    apply(enc_i(5, 8, 9, 16'h0010));
    chk_ctl("R8", 0, 0, 0, 1, 0, 0, 0, 0, 2, 0, 0, 0, 0);
  endtask

  task automatic t_jumps;
    apply({6'd2, 26'h123_4567});
    chk_ctl("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9", "j tgt", 32'(jmp_tgt), 32'h0123_4567);
    apply({6'd3, 26'h000_0100});
    chk_ctl("R9", 1, 2, 31, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0);
  endtask

  task automatic t_illegal;
    int bad_ops[6] = '{1, 9, 14, 33, 41, 63};
    for (int k = 0; k < 6; k++) begin
      apply(enc_i(bad_ops[k], 1, 2, 16'hFFFF));
      chk_ctl("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    end
    apply(enc_r(1, 2, 3, 33));
    chk_ctl("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    apply(enc_r(1, 2, 3, 9));
    chk_ctl("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_exclusive;
    for (int op = 0; op < 64; op++) begin
      apply(enc_i(op, 4, 5, 16'h0808));
      chk("R11", "one effect", 32'($countones({mem_rd, mem_wr, br_type != 2'd0, jump, jump_reg}) <= 1), 32'd1);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    instr = 32'h0;
    repeat (2) @(posedge clk);
    t_zero_word();
    t_fields();
    t_reg_ops();
    t_reg_jump();
    t_imm_arith();
    t_upper();
    t_loads();
    t_stores();
    t_branches();
    t_jumps();
    t_illegal();
    t_exclusive();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule